// File: doc/BRIEF.md
# Grouped Peripheral Interrupt Pending Register

This block gathers a small set of peripheral event sources behind one shared interrupt request for a core interrupt controller. Each source owns a pending bit at an even position of an 8-bit register. A hardware event sets that bit. It also sets one main-level pending flag, which stands for the whole group in the controller's main pending register. Each source can add to the request only while its own mask bit is set. The request reaches the CPU only when the group's global enable is high.

Software reaches the block through a simple strobe interface. A read returns the register and then clears every pending bit. A write ORs ones into the pending bits, so software can raise an interrupt in the same way a hardware event does. A separate strobe loads the per-source mask from the same write data. When the controller takes the vector, it pulses an acknowledge. This clears only the main-level flag and leaves the per-source bits as they were, so the handler can still read which sources fired.

Top module: `perint_group`

## Requirements
- R1: After reset, the read data is 0xAA, the mask reads 0x00, and the main pending flag and the request are both low.
- R2: An event pulse on source i sets register bit 2*i from the next clock onward. No other pending bit changes.
- R3: Any hardware event, or any write that sets at least one pending bit, sets the main pending flag from the next clock onward.
- R4: A vector acknowledge clears the main pending flag on the next clock and leaves the per-source bits unchanged. If a set arrives in the same cycle as the acknowledge, the set wins.
- R5: During a read cycle, the read data shows the value from before the clear. After that clock edge, every pending bit reads 0.
- R6: If a hardware event and a read fall in the same cycle, the event's bit is still set after the read.
- R7: A write sets each pending bit whose data bit is 1 at an even position. Data bits that are 0 leave the pending bits as they were.
- R8: The odd bits 1, 3, 5 and 7 always read as 1 and ignore writes. A write with ones only at odd positions sets no pending bit and does not set the main flag.
- R9: A mask write loads mask bit 2*i from data bit 2*i. The mask output shows the loaded bits at even positions and 0 at odd positions.
- R10: The request is high exactly when the main flag is set, the global enable is high, and at least one source has both its pending bit and its mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt_i | input | NUM_SRC | Single-cycle event pulses; source i maps to bit 2*i |
| bus_rd_i | input | 1 | Read strobe; clears pending bits at the clock edge |
| bus_wr_i | input | 1 | Write strobe; sets pending bits from bus_wdata_i |
| mask_wr_i | input | 1 | Mask load strobe; takes bus_wdata_i |
| bus_wdata_i | input | 2*NUM_SRC | Write data |
| grp_en_i | input | 1 | Global enable of the shared request |
| vec_ack_i | input | 1 | Vector taken; clears the main pending flag |
| bus_rdata_o | output | 2*NUM_SRC | Pending register with the odd bits forced to 1 |
| mask_o | output | 2*NUM_SRC | Mask register at even positions |
| main_pend_o | output | 1 | Main-level pending flag of the group |
| irq_o | output | 1 | Gated shared request |

## Verification
Every state bit shows up directly at a port. A wrong pending bit or mask bit appears on bus_rdata_o or mask_o one clock after the stimulus that caused it. A wrong main flag shows on main_pend_o on the same schedule. The bench sweeps every write pattern and every mask, pending and enable combination, so a broken gate term is seen on irq_o in the cycle after setup. A broken priority between a set and a clear shows on the cycle right after the collision.

// File: rtl/perint_pkg.sv
package perint_pkg;
  typedef enum logic [1:0] {
    FLAG_HOLD = 2'b00,
    FLAG_SET  = 2'b01,
    FLAG_CLR  = 2'b10
  } flag_op_e;

  function automatic flag_op_e flag_op(input logic set, input logic clr);
    if (set)      return FLAG_SET;
    else if (clr) return FLAG_CLR;
    else          return FLAG_HOLD;
  endfunction
endpackage

// File: rtl/perint_pend_bank.sv
module perint_pend_bank
  import perint_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] pend_d;
  logic [NUM_SRC-1:0] pend_en;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    flag_op_e op;
    always_comb begin
      op         = flag_op(set_i[g], clr_i);
      pend_en[g] = (op != FLAG_HOLD);
      pend_d[g]  = (op == FLAG_SET);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_q[g] <= 1'b0;
      else if (pend_en[g]) pend_q[g] <= pend_d[g];
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/perint_main_flag.sv
module perint_main_flag
  import perint_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  flag_op_e op;
  logic     flag_q;
  logic     flag_d;
  logic     flag_en;

  always_comb begin
    op      = flag_op(set_i, clr_i);
    flag_en = (op != FLAG_HOLD);
    flag_d  = (op == FLAG_SET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/perint_mask_reg.sv
module perint_mask_reg #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_i,
  input  logic [NUM_SRC-1:0] d_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] mask_d;

  always_comb mask_d = d_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (ld_i) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/perint_group.sv
module perint_group #(
  parameter  int NUM_SRC = 4,
  localparam int REG_W   = 2 * NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_evt_i,
  input  logic               bus_rd_i,
  input  logic               bus_wr_i,
  input  logic               mask_wr_i,
  input  logic [REG_W-1:0]   bus_wdata_i,
  input  logic               grp_en_i,
  input  logic               vec_ack_i,
  output logic [REG_W-1:0]   bus_rdata_o,
  output logic [REG_W-1:0]   mask_o,
  output logic               main_pend_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] wr_even;
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] mask;
  logic               any_set;
  logic               hit;

  // Pick the even data bits; the odd positions are reserved.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_map
    assign wr_even[g]          = bus_wdata_i[2*g];
    assign bus_rdata_o[2*g]    = pend[g];
    assign bus_rdata_o[2*g+1]  = 1'b1;
    assign mask_o[2*g]         = mask[g];
    assign mask_o[2*g+1]       = 1'b0;
  end

  always_comb begin
    set_vec = src_evt_i | (bus_wr_i ? wr_even : '0);
    any_set = |set_vec;
    hit     = |(pend & mask);
    irq_o   = main_pend_o & grp_en_i & hit;
  end

  perint_pend_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (bus_rd_i),
    .pend_o (pend)
  );

  perint_main_flag u_main (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (any_set),
    .clr_i  (vec_ack_i),
    .flag_o (main_pend_o)
  );

  perint_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_i   (mask_wr_i),
    .d_i    (wr_even),
    .mask_o (mask)
  );
endmodule

// File: rtl/perint_group_chk.sv
module perint_group_chk #(
  parameter int NUM_SRC = 4,
  localparam int REG_W  = 2 * NUM_SRC
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_evt_i,
  input logic               bus_rd_i,
  input logic               bus_wr_i,
  input logic               mask_wr_i,
  input logic [REG_W-1:0]   bus_wdata_i,
  input logic               grp_en_i,
  input logic               vec_ack_i,
  input logic [REG_W-1:0]   bus_rdata_o,
  input logic [REG_W-1:0]   mask_o,
  input logic               main_pend_o,
  input logic               irq_o
);
  function automatic logic [REG_W-1:0] odd_ones();
    logic [REG_W-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_SRC; i++) v[2*i+1] = 1'b1;
    return v;
  endfunction
  localparam logic [REG_W-1:0] ODD = odd_ones();

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    // R2
    evt_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_evt_i[g] |=> bus_rdata_o[2*g]);
  end

  // R3
  evt_sets_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt_i != '0) |=> main_pend_o);

  // R4
  ack_clears_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack_i && src_evt_i == '0 && !bus_wr_i) |=> !main_pend_o);

  // R4
  ack_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack_i && !bus_rd_i && !bus_wr_i && src_evt_i == '0) |=> $stable(bus_rdata_o));

  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && !bus_wr_i && src_evt_i == '0) |=> (bus_rdata_o == ODD));

  // R8
  odd_bits_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata_o & ODD) == ODD);

  // R9
  mask_odd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_i |=> ((mask_o & ODD) == '0));

  // R10
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (main_pend_o && grp_en_i));
endmodule

bind perint_group perint_group_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_evt_i(src_evt_i), .bus_rd_i(bus_rd_i),
  .bus_wr_i(bus_wr_i), .mask_wr_i(mask_wr_i), .bus_wdata_i(bus_wdata_i),
  .grp_en_i(grp_en_i), .vec_ack_i(vec_ack_i), .bus_rdata_o(bus_rdata_o),
  .mask_o(mask_o), .main_pend_o(main_pend_o), .irq_o(irq_o)
);

// File: tb/sim_perint_group.sv
`timescale 1ns/1ps
module sim_perint_group;
  localparam int N = 4;
  localparam int W = 2 * N;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] src_evt_i;
  logic         bus_rd_i, bus_wr_i, mask_wr_i, grp_en_i, vec_ack_i;
  logic [W-1:0] bus_wdata_i;
  logic [W-1:0] bus_rdata_o, mask_o;
  logic         main_pend_o, irq_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  perint_group #(.NUM_SRC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .src_evt_i(src_evt_i), .bus_rd_i(bus_rd_i),
    .bus_wr_i(bus_wr_i), .mask_wr_i(mask_wr_i), .bus_wdata_i(bus_wdata_i),
    .grp_en_i(grp_en_i), .vec_ack_i(vec_ack_i), .bus_rdata_o(bus_rdata_o),
    .mask_o(mask_o), .main_pend_o(main_pend_o), .irq_o(irq_o)
  );

  function automatic logic [W-1:0] spread(input logic [N-1:0] v);
    logic [W-1:0] r = '0;
    for (int i = 0; i < N; i++) r[2*i] = v[i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    src_evt_i = '0; bus_rd_i = 0; bus_wr_i = 0; mask_wr_i = 0;
    vec_ack_i = 0; bus_wdata_i = '0;
  endtask

  task automatic clear_all();
    bus_rd_i = 1; vec_ack_i = 1; tick(); idle();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(); grp_en_i = 0; rst_n = 0;
    #12; rst_n = 1; #1;
    tick();
    // R1 reset state
    chk("R1 rdata", bus_rdata_o, 8'hAA);
    chk("R1 mask", mask_o, 8'h00);
    chk("R1 main", {7'd0, main_pend_o}, 8'd0);
    chk("R1 irq", {7'd0, irq_o}, 8'd0);

    // R2, R3 each source alone
    for (int i = 0; i < N; i++) begin
      clear_all();
      src_evt_i = N'(1) << i; tick(); idle();
      chk("R2 single source", bus_rdata_o, 8'hAA | (8'h01 << (2*i)));
      chk("R3 main set by event", {7'd0, main_pend_o}, 8'd1);
    end

    // R5 read: pre-clear value visible, cleared afterwards
    clear_all();
    src_evt_i = 4'b1011; tick(); idle();
    bus_rd_i = 1; #1;
    chk("R5 pre-clear read", bus_rdata_o, 8'hAA | spread(4'b1011));
    tick(); idle();
    chk("R5 cleared", bus_rdata_o, 8'hAA);

    // R6 event during read survives
    src_evt_i = 4'b0110; tick(); idle();
    bus_rd_i = 1; src_evt_i = 4'b0001; tick(); idle();
    chk("R6 set wins over read", bus_rdata_o, 8'hAA | spread(4'b0001));

    // R4 ack clears only main
    clear_all();
    src_evt_i = 4'b1100; tick(); idle();
    vec_ack_i = 1; tick(); idle();
    chk("R4 main cleared", {7'd0, main_pend_o}, 8'd0);
    chk("R4 bits kept", bus_rdata_o, 8'hAA | spread(4'b1100));
    vec_ack_i = 1; src_evt_i = 4'b0001; tick(); idle();
    chk("R4 set wins over ack", {7'd0, main_pend_o}, 8'd1);

    // R7 R8 write sweep
    for (int p = 0; p < 16; p++) begin
      clear_all();
      bus_wr_i = 1; bus_wdata_i = spread(N'(p)) | 8'hAA; tick(); idle();
      chk("R7/R8 write sets", bus_rdata_o, 8'hAA | spread(N'(p)));
      chk("R3/R8 main after write", {7'd0, main_pend_o}, {7'd0, p != 0});
      bus_wr_i = 1; bus_wdata_i = 8'h00; tick(); idle();
      chk("R7 zero write keeps", bus_rdata_o, 8'hAA | spread(N'(p)));
    end

    // R9 mask sweep
    for (int m = 0; m < 16; m++) begin
      mask_wr_i = 1; bus_wdata_i = spread(N'(m)) | 8'hAA; tick(); idle();
      chk("R9 mask load", mask_o, spread(N'(m)));
    end

    // R10 request sweep
    for (int e = 0; e < 2; e++)
      for (int m = 0; m < 16; m++)
        for (int p = 0; p < 16; p++) begin
          clear_all();
          grp_en_i = e[0];
          mask_wr_i = 1; bus_wdata_i = spread(N'(m)); tick(); idle();
          bus_wr_i = 1; bus_wdata_i = spread(N'(p)); tick(); idle();
          chk("R10 irq", {7'd0, irq_o}, {7'd0, (e == 1) && ((m & p) != 0)});
          vec_ack_i = 1; tick(); idle();
          chk("R10 irq after ack", {7'd0, irq_o}, 8'd0);
        end

    finish_run();
  end
endmodule